// File: doc/BRIEF.md
# Reservation Station Pool with Oldest-First Dispatch

This block holds instructions that wait for one non-pipelined functional unit. Each slot stores an opcode, the destination reorder-buffer tag, a program-order sequence number, and two source operands. A source operand holds either its value or the tag of the instruction that will produce it. The pool watches a single result broadcast bus and copies the value into every waiting operand whose tag matches. A slot whose operands are both present is ready. When the unit reports that it is idle, the pool sends the ready slot that is oldest in program order.

The slot count is a parameter. The same block serves as a two-slot pool in front of a multiply/divide unit and as a four-slot pool in front of an add/subtract unit. A slot is released in the cycle its instruction is sent to the unit, not at writeback. A new instruction can use the released slot from the following cycle.

Top module: `rs_pool`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pool_full` is 0 and `disp_valid` is 0.
- R2: An instruction presented with `iss_valid`=1 is accepted at the clock edge only if `pool_full` is 0. `pool_full` is 1 exactly when every slot is occupied. An issue presented while `pool_full`=1 is dropped and never reaches the dispatch port.
- R3: `disp_valid` is 0 whenever `unit_busy` is 1. When `unit_busy` is 0, `disp_valid` is 1 in the same cycle if at least one occupied slot has both operands present.
- R4: When several slots are ready, the dispatched one is the earliest accepted. Ordering uses a SEQ_W-bit sequence number with wrap-around comparison and stays correct across counter wrap, provided the distance in accepted issues between any two occupied slots stays below 2^(SEQ_W-1).
- R5: A waiting operand whose tag equals `cdb_tag` while `cdb_valid`=1 takes `cdb_data` at that clock edge. The slot cannot dispatch in the broadcast cycle itself, and it can dispatch in the next cycle.
- R6: If both operands of a slot wait on the same tag, a single broadcast of that tag fills both of them at the same edge.
- R7: An issued operand marked not present, whose tag matches a broadcast in the same cycle as the issue, is stored with the broadcast value and is treated as present.
- R8: A slot is freed at the edge that ends its dispatch cycle. `pool_full` stays 1 during that dispatch cycle and falls in the next cycle, when a new issue may take the slot.
- R9: The dispatch port presents the opcode, both operand values and the reorder-buffer tag of the chosen slot. Operand a is the first source and operand b is the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode of the issued instruction |
| iss_rob | input | TAG_W | Reorder-buffer tag of the issued instruction |
| iss_a_rdy | input | 1 | Source a value is present |
| iss_a_tag | input | TAG_W | Producer tag for source a |
| iss_a_val | input | DATA_W | Source a value |
| iss_b_rdy | input | 1 | Source b value is present |
| iss_b_tag | input | TAG_W | Producer tag for source b |
| iss_b_val | input | DATA_W | Source b value |
| pool_full | output | 1 | No free slot this cycle |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_data | input | DATA_W | Broadcast result value |
| unit_busy | input | 1 | Functional unit is executing |
| disp_valid | output | 1 | An instruction is sent to the unit this cycle |
| disp_op | output | OP_W | Opcode sent |
| disp_rob | output | TAG_W | Reorder-buffer tag sent |
| disp_a | output | DATA_W | Source a value sent |
| disp_b | output | DATA_W | Source b value sent |

## Verification
The assertions check several properties on every cycle:
- no dispatch occurs while the unit is busy;
- at most one slot is granted;
- issues are written only into free slots;
- `pool_full` keeps its level or falls according to whether a dispatch happened;
- a granted slot is empty one cycle later;
- a shared-tag broadcast fills both operands at once.

Whether the chosen slot is really the oldest, especially after the sequence counter wraps, can only be shown by the bench scenarios. The same holds for the one-cycle wake-up delay, the capture at issue time, and the silent drop of an issue into a full pool. The bench compares these against an ordering model that uses unbounded issue counts.

// File: rtl/rs_pkg.sv
package rs_pkg;
   // True when sequence number a was assigned before b, modulo 2^w.
   function automatic logic seq_before(input logic [31:0] a, input logic [31:0] b,
                                       input int unsigned w);
      logic [31:0] diff;
      diff = a - b;
      return diff[w-1];
   endfunction
endpackage

// File: rtl/rs_slot.sv
module rs_slot #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 3,
   parameter int OP_W   = 4,
   parameter int SEQ_W  = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic                        clr,
   input  logic [OP_W-1:0]             ld_op,
   input  logic [TAG_W-1:0]            ld_rob,
   input  logic [SEQ_W-1:0]            ld_seq,
   input  logic [1:0]                  ld_rdy,
   input  logic [1:0][TAG_W-1:0]       ld_tag,
   input  logic [1:0][DATA_W-1:0]      ld_val,
   input  logic                        cdb_valid,
   input  logic [TAG_W-1:0]            cdb_tag,
   input  logic [DATA_W-1:0]           cdb_data,
   output logic                        valid_o,
   output logic                        ready_o,
   output logic [OP_W-1:0]             op_o,
   output logic [TAG_W-1:0]            rob_o,
   output logic [SEQ_W-1:0]            seq_o,
   output logic [1:0][DATA_W-1:0]      val_o
);
   logic                   occ_q;
   logic [1:0]             rdy_q;
   logic [1:0][TAG_W-1:0]  tag_q;
   logic [1:0][DATA_W-1:0] val_q;
   logic [OP_W-1:0]        op_q;
   logic [TAG_W-1:0]       rob_q;
   logic [SEQ_W-1:0]       seq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= 1'b0;
         op_q  <= '0;
         rob_q <= '0;
         seq_q <= '0;
      end else if (load) begin
         occ_q <= 1'b1;
         op_q  <= ld_op;
         rob_q <= ld_rob;
         seq_q <= ld_seq;
      end else if (clr) begin
         occ_q <= 1'b0;
      end
   end

   for (genvar k = 0; k < 2; k++) begin : g_src
      logic hit_new, hit_old;
      assign hit_new = !ld_rdy[k] && cdb_valid && (cdb_tag == ld_tag[k]);
      assign hit_old = occ_q && !rdy_q[k] && cdb_valid && (cdb_tag == tag_q[k]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdy_q[k] <= 1'b0;
            tag_q[k] <= '0;
            val_q[k] <= '0;
         end else if (load) begin
            rdy_q[k] <= ld_rdy[k] | hit_new;
            tag_q[k] <= ld_tag[k];
            val_q[k] <= hit_new ? cdb_data : ld_val[k];
         end else if (hit_old) begin
            rdy_q[k] <= 1'b1;
            val_q[k] <= cdb_data;
         end
      end
   end

   assign valid_o = occ_q;
   assign ready_o = occ_q & rdy_q[0] & rdy_q[1];
   assign op_o    = op_q;
   assign rob_o   = rob_q;
   assign seq_o   = seq_q;
   assign val_o   = val_q;

   AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !occ_q); // R8
   AST_GRANT_NEEDS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> (occ_q && rdy_q[0] && rdy_q[1])); // R5
   AST_SHARED_TAG_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_q && !rdy_q[0] && !rdy_q[1] && tag_q[0] == tag_q[1] &&
       cdb_valid && cdb_tag == tag_q[0])
      |=> (rdy_q[0] && rdy_q[1] && val_q[0] == val_q[1])); // R6
endmodule

// File: rtl/rs_free_find.sv
module rs_free_find #(
   parameter int N = 4
) (
   input  logic [N-1:0] free_i,
   output logic [N-1:0] pick_o
);
   always_comb begin
      logic found;
      found  = 1'b0;
      pick_o = '0;
      for (int i = 0; i < N; i++) begin
         if (free_i[i] && !found) begin
            pick_o[i] = 1'b1;
            found     = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick
   import rs_pkg::*;
#(
   parameter int N     = 4,
   parameter int SEQ_W = 5
) (
   input  logic             en_i,
   input  logic [N-1:0]     ready_i,
   input  logic [SEQ_W-1:0] seq_i [N],
   output logic [N-1:0]     grant_o
);
   if (N == 2) begin : g_pair
      logic first_older;
      assign first_older = seq_before(32'(seq_i[0]), 32'(seq_i[1]), SEQ_W);
      assign grant_o[0] = en_i & ready_i[0] & (!ready_i[1] | first_older);
      assign grant_o[1] = en_i & ready_i[1] & (!ready_i[0] | !first_older);
   end else begin : g_wide
      always_comb begin
         for (int i = 0; i < N; i++) begin
            logic win;
            win = ready_i[i];
            for (int j = 0; j < N; j++) begin
               if (j != i && ready_i[j] &&
                   !seq_before(32'(seq_i[i]), 32'(seq_i[j]), SEQ_W))
                  win = 1'b0;
            end
            grant_o[i] = en_i & win;
         end
      end
   end
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
   parameter int NUM_ENTRIES = 4,
   parameter int DATA_W      = 32,
   parameter int TAG_W       = 3,
   parameter int OP_W        = 4,
   parameter int SEQ_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [TAG_W-1:0]  iss_rob,
   input  logic              iss_a_rdy,
   input  logic [TAG_W-1:0]  iss_a_tag,
   input  logic [DATA_W-1:0] iss_a_val,
   input  logic              iss_b_rdy,
   input  logic [TAG_W-1:0]  iss_b_tag,
   input  logic [DATA_W-1:0] iss_b_val,
   output logic              pool_full,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_data,
   input  logic              unit_busy,
   output logic              disp_valid,
   output logic [OP_W-1:0]   disp_op,
   output logic [TAG_W-1:0]  disp_rob,
   output logic [DATA_W-1:0] disp_a,
   output logic [DATA_W-1:0] disp_b
);
   localparam int MIN_SEQ_W = $clog2(NUM_ENTRIES) + 2;

   if (NUM_ENTRIES < 2) begin : g_bad_depth
      $error("rs_pool: NUM_ENTRIES must be at least 2");
   end
   if (SEQ_W < MIN_SEQ_W || SEQ_W > 32) begin : g_bad_seq
      $error("rs_pool: SEQ_W out of range for NUM_ENTRIES");
   end
   if (TAG_W < 1 || OP_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("rs_pool: widths must be positive");
   end

   logic [NUM_ENTRIES-1:0]   valid_vec, ready_vec, free_pick, load_vec, grant;
   logic [OP_W-1:0]          e_op  [NUM_ENTRIES];
   logic [TAG_W-1:0]         e_rob [NUM_ENTRIES];
   logic [SEQ_W-1:0]         e_seq [NUM_ENTRIES];
   logic [1:0][DATA_W-1:0]   e_val [NUM_ENTRIES];
   logic [SEQ_W-1:0]         seq_ctr;
   logic                     accept;

   assign pool_full = &valid_vec;
   assign accept    = iss_valid & ~pool_full;
   assign load_vec  = accept ? free_pick : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)      seq_ctr <= '0;
      else if (accept) seq_ctr <= seq_ctr + 1'b1;
   end

   rs_free_find #(.N(NUM_ENTRIES)) u_free (
      .free_i (~valid_vec),
      .pick_o (free_pick)
   );

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
      rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .SEQ_W(SEQ_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load_vec[i]),
         .clr       (grant[i]),
         .ld_op     (iss_op),
         .ld_rob    (iss_rob),
         .ld_seq    (seq_ctr),
         .ld_rdy    ({iss_b_rdy, iss_a_rdy}),
         .ld_tag    ({iss_b_tag, iss_a_tag}),
         .ld_val    ({iss_b_val, iss_a_val}),
         .cdb_valid (cdb_valid),
         .cdb_tag   (cdb_tag),
         .cdb_data  (cdb_data),
         .valid_o   (valid_vec[i]),
         .ready_o   (ready_vec[i]),
         .op_o      (e_op[i]),
         .rob_o     (e_rob[i]),
         .seq_o     (e_seq[i]),
         .val_o     (e_val[i])
      );
   end

   rs_age_pick #(.N(NUM_ENTRIES), .SEQ_W(SEQ_W)) u_pick (
      .en_i    (~unit_busy),
      .ready_i (ready_vec),
      .seq_i   (e_seq),
      .grant_o (grant)
   );

   assign disp_valid = |grant;

   always_comb begin
      disp_op  = '0;
      disp_rob = '0;
      disp_a   = '0;
      disp_b   = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (grant[i]) begin
            disp_op  = disp_op  | e_op[i];
            disp_rob = disp_rob | e_rob[i];
            disp_a   = disp_a   | e_val[i][0];
            disp_b   = disp_b   | e_val[i][1];
         end
      end
   end

   AST_IDLE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      unit_busy |-> !disp_valid); // R3
   AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R4
   AST_LOAD_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (|load_vec) |-> ((load_vec & valid_vec) == '0)); // R2
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pool_full && !disp_valid) |=> pool_full); // R2
   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pool_full && disp_valid) |=> !pool_full); // R8
endmodule

// File: tb/sim_rs_pool.sv
module sim_rs_pool;
   localparam int CLK_PERIOD = 10;
   localparam int NE = 4, DW = 32, TW = 3, OW = 4, SW = 5;
   localparam int WINDOW = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic iss_valid = 0, iss_a_rdy = 0, iss_b_rdy = 0, cdb_valid = 0, unit_busy = 0;
   logic [OW-1:0] iss_op = '0;
   logic [TW-1:0] iss_rob = '0, iss_a_tag = '0, iss_b_tag = '0, cdb_tag = '0;
   logic [DW-1:0] iss_a_val = '0, iss_b_val = '0, cdb_data = '0;
   logic pool_full, disp_valid;
   logic [OW-1:0] disp_op;
   logic [TW-1:0] disp_rob;
   logic [DW-1:0] disp_a, disp_b;

   int n_tests = 0, n_fail = 0, n_iss = 0, n_disp = 0;

   // reference model, ordered by an unbounded issue count
   bit            mv [NE], mar [NE], mbr [NE];
   int            mord [NE];
   logic [TW-1:0] mat [NE], mbt [NE], mrob [NE];
   logic [DW-1:0] mav [NE], mbv [NE];
   logic [OW-1:0] mop [NE];

   always #(CLK_PERIOD/2) clk = ~clk;

   rs_pool #(.NUM_ENTRIES(NE), .DATA_W(DW), .TAG_W(TW), .OP_W(OW), .SEQ_W(SW)) u0 (
      .clk, .rst_n, .iss_valid, .iss_op, .iss_rob, .iss_a_rdy, .iss_a_tag, .iss_a_val,
      .iss_b_rdy, .iss_b_tag, .iss_b_val, .pool_full, .cdb_valid, .cdb_tag, .cdb_data,
      .unit_busy, .disp_valid, .disp_op, .disp_rob, .disp_a, .disp_b);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   function automatic bit m_full();
      for (int i = 0; i < NE; i++) if (!mv[i]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic int m_pick();
      int best = -1;
      if (unit_busy) return -1;
      for (int i = 0; i < NE; i++)
         if (mv[i] && mar[i] && mbr[i] && (best < 0 || mord[i] < mord[best])) best = i;
      return best;
   endfunction

   function automatic int m_oldest();
      int o = n_iss;
      for (int i = 0; i < NE; i++) if (mv[i] && mord[i] < o) o = mord[i];
      return o;
   endfunction

   // inputs are already set after a falling edge; check, update the model, advance
   task automatic tick();
      int p, f;
      bit ef;
      #1;
      ef = m_full();
      p  = m_pick();
      chk("R2 R8 full", pool_full, ef);
      chk("R3 dispatch valid", disp_valid, p >= 0);
      if (p >= 0) begin
         chk("R4 R9 rob", disp_rob, mrob[p]);
         chk("R9 op", disp_op, mop[p]);
         chk("R9 a", disp_a, mav[p]);
         chk("R9 b", disp_b, mbv[p]);
      end
      if (disp_valid) n_disp++;
      f = -1;
      for (int i = 0; i < NE; i++) if (!mv[i] && f < 0) f = i;
      if (p >= 0) mv[p] = 0;
      for (int i = 0; i < NE; i++) if (mv[i] && cdb_valid) begin
         if (!mar[i] && mat[i] == cdb_tag) begin mar[i] = 1; mav[i] = cdb_data; end
         if (!mbr[i] && mbt[i] == cdb_tag) begin mbr[i] = 1; mbv[i] = cdb_data; end
      end
      if (iss_valid && !ef) begin
         mv[f] = 1; mord[f] = n_iss; n_iss++;
         mop[f] = iss_op; mrob[f] = iss_rob;
         mat[f] = iss_a_tag; mbt[f] = iss_b_tag;
         mar[f] = iss_a_rdy; mav[f] = iss_a_val;
         mbr[f] = iss_b_rdy; mbv[f] = iss_b_val;
         if (!iss_a_rdy && cdb_valid && cdb_tag == iss_a_tag) begin mar[f] = 1; mav[f] = cdb_data; end
         if (!iss_b_rdy && cdb_valid && cdb_tag == iss_b_tag) begin mbr[f] = 1; mbv[f] = cdb_data; end
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      iss_valid = 0; cdb_valid = 0; unit_busy = 0;
   endtask

   task automatic iss(input bit ar, input int at, input int av, input bit br,
                      input int bt, input int bv, input int op, input int rob);
      iss_valid = 1;
      iss_a_rdy = ar; iss_a_tag = TW'(at); iss_a_val = DW'(av);
      iss_b_rdy = br; iss_b_tag = TW'(bt); iss_b_val = DW'(bv);
      iss_op = OW'(op); iss_rob = TW'(rob);
   endtask

   task automatic bcast(input int t, input int d);
      cdb_valid = 1; cdb_tag = TW'(t); cdb_data = DW'(d);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int disp_before;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NE; i++) mv[i] = 0;
      repeat (3) @(negedge clk);
      chk("R1 full in reset", pool_full, 0);
      chk("R1 dispatch in reset", disp_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 full after reset", pool_full, 0);
      chk("R1 dispatch after reset", disp_valid, 0);

      // R5: no wake in the broadcast cycle, dispatch one cycle later
      idle(); iss(0, 5, 0, 1, 0, 11, 1, 1); tick();
      idle(); bcast(5, 77);
      #1 chk("R5 same cycle", disp_valid, 0);
      tick();
      idle();
      #1 chk("R5 next cycle", disp_valid, 1);
      chk("R5 value", disp_a, 77);
      tick();

      // R6: both sources wait on one tag
      idle(); iss(0, 3, 0, 0, 3, 0, 2, 2); tick();
      idle(); bcast(3, 55); tick();
      idle();
      #1 chk("R6 ready", disp_valid, 1);
      chk("R6 a", disp_a, 55);
      chk("R6 b", disp_b, 55);
      tick();

      // R7: broadcast during the issue cycle
      idle(); iss(0, 6, 0, 1, 0, 9, 3, 3); bcast(6, 66); tick();
      idle();
      #1 chk("R7 ready", disp_valid, 1);
      chk("R7 a", disp_a, 66);
      tick();

      // R2, R3, R8: fill, attempt issue while full, release timing
      disp_before = n_disp;
      for (int k = 0; k < NE; k++) begin
         idle(); unit_busy = 1; iss(1, 0, 100 + k, 1, 0, k, 4, k); tick();
      end
      idle(); unit_busy = 1; iss(1, 0, 999, 1, 0, 999, 7, 7);
      #1 chk("R2 full", pool_full, 1);
      chk("R3 busy blocks", disp_valid, 0);
      tick();
      idle();
      #1 chk("R8 full during dispatch", pool_full, 1);
      tick();
      idle(); iss(1, 0, 200, 1, 0, 201, 5, 5);
      #1 chk("R8 freed next cycle", pool_full, 0);
      tick();
      idle(); repeat (8) tick();
      chk("R2 dropped issue absent", n_disp - disp_before, NE + 1);

      // R4: older waiting slots outrank a younger ready one
      idle(); unit_busy = 1; iss(0, 1, 0, 1, 0, 0, 1, 1); tick();
      idle(); unit_busy = 1; iss(0, 1, 0, 1, 0, 0, 1, 2); tick();
      idle(); unit_busy = 1; iss(1, 0, 0, 1, 0, 0, 1, 3); tick();
      idle(); unit_busy = 1; bcast(1, 42); tick();
      for (int k = 1; k <= 3; k++) begin
         idle();
         #1 chk("R4 order", disp_rob, k);
         tick();
      end

      // random mix, long enough to wrap the sequence counter many times (R4)
      for (int c = 0; c < 6000; c++) begin
         int w;
         idle();
         unit_busy = ($urandom % 4) == 0;
         if ($urandom % 2) begin
            w = -1;
            for (int i = 0; i < NE; i++)
               if (mv[i] && !(mar[i] && mbr[i]) && (w < 0 || mord[i] < mord[w])) w = i;
            if (w >= 0 && ($urandom % 2)) bcast(mar[w] ? int'(mbt[w]) : int'(mat[w]), $urandom);
            else bcast($urandom % 8, $urandom);
         end
         if (($urandom % 3) != 0 && (n_iss - m_oldest()) < WINDOW)
            iss($urandom % 2, $urandom % 8, $urandom, $urandom % 2, $urandom % 8, $urandom,
                $urandom % 16, $urandom % 8);
         tick();
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule